// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is a slave on a two-wire serial bus. Through it a bus master reads and writes a small byte-addressed register file that sits beside it on the chip. Both bus lines are first brought into the system clock domain. The block then recognises bus framing, and it answers one of two fixed 7-bit device codes. The `addrSel` pin picks which of the two codes applies. The block pulls the data line low through an open-drain enable and never drives it high.

A write transfer carries three things in order: the device byte, one byte that loads the internal register pointer, and any number of data bytes. Each data byte produces a single-cycle write strobe. The pointer then moves on by one, so a stream of data bytes fills consecutive registers. A read transfer returns the register at the current pointer and advances after every byte. It keeps going while the master acknowledges and stops driving the line when the master does not. A master normally sets the pointer with a short write and then issues a repeated START followed by a read.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset, `sdaOe` is 0, `regWrEn` is 0 and `regAddr` is 0.
- R2: The device code is 7'b0011000 when `addrSel` is 0 and 7'b0011001 when it is 1, so the write bytes are 0x30 and 0x32. The first byte after START is taken MSB first, with bit 0 as R/W (1 = read). On a match the block pulls SDA low for the 9th clock. On a mismatch it leaves SDA released for that byte and for all later bytes until the next START.
- R3: In a write, the byte after the device byte is acknowledged and loaded into the register pointer.
- R4: Each data byte in a write is acknowledged. It produces one `regWrEn` pulse, with `regWrData` equal to the byte and `regAddr` equal to the pointer.
- R5: The pointer increments by one in the cycle after each `regWrEn` pulse and wraps from the top address to 0. A burst of N data bytes therefore writes N consecutive registers.
- R6: In a read, the register at the pointer is shifted out MSB first. `sdaOe` only rises while the synchronized SCL is low, and SDA stays stable while SCL is high.
- R7: After each byte sent in a read, the pointer increments. If the master acknowledges (SDA low on the 9th clock), the next byte follows. If the master does not acknowledge, SDA is released.
- R8: STOP (SDA rising while SCL is high) releases SDA in the next cycle. Bytes clocked after a STOP and before a new START are neither acknowledged nor written.
- R9: A START (SDA falling while SCL is high) seen at any point, including a repeated START inside a transfer, restarts device-code matching. The register pointer is kept.
- R10: `regWrEn` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line, asynchronous |
| sdaIn | input | 1 | Bus data line as seen on the wire, asynchronous |
| sdaOe | output | 1 | When 1, the pad pulls SDA low |
| addrSel | input | 1 | Selects which of the two device codes is answered |
| regAddr | output | ADDR_W | Register pointer, used for both writes and reads |
| regWrData | output | BYTE_W | Write data, valid with regWrEn |
| regWrEn | output | 1 | Single-cycle register write strobe |
| regRdEn | output | 1 | High in the cycle regRdData is sampled |
| regRdData | input | BYTE_W | Register contents at regAddr |

## Verification
The bench uses the default parameters: two synchronizer stages, 8-bit bytes and an 8-bit register pointer. With an 8-bit pointer, a burst started at 0xFE reaches the wrap to 0x00 in three bytes. A bus half-period of ten system clocks leaves enough margin after the synchronizer latency that acknowledge and read bits can be sampled in the middle of the SCL high phase. Both `addrSel` values are used against both device codes, so mismatches are tested in each direction. The bench's register model answers reads combinationally, so a repeated-START read returns exactly the bytes written earlier.

// File: rtl/i2c_slave_pkg.sv
package i2c_slave_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_WAIT,
    ST_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_TX_WAIT
  } slvState_t;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_SUB,
    PH_WR,
    PH_RD
  } slvPhase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic shiftIn;
    logic loadTx;
    logic shiftTx;
    logic setPtr;
    logic wrStrobe;
    logic incPtr;
  } dpCtl_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe[i] <= 1'b1;
          sdaPipe[i] <= 1'b1;
        end else if (i == 0) begin
          sclPipe[i] <= sclIn;
          sdaPipe[i] <= sdaIn;
        end else begin
          sclPipe[i] <= sclPipe[(i == 0) ? 0 : i-1];
          sdaPipe[i] <= sdaPipe[(i == 0) ? 0 : i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclPipe[STAGES-1];
      sdaPrev <= sdaPipe[STAGES-1];
    end
  end

  assign sclS     = sclPipe[STAGES-1];
  assign sdaS     = sdaPipe[STAGES-1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
  import i2c_slave_pkg::*;
#(
  parameter int          BYTE_W   = 8,
  parameter logic [6:0]  DEV_BASE = 7'b0011000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclS,
  input  logic              sdaS,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              addrSel,
  input  logic [2:0]        bitCnt,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txMsb,
  output dpCtl_t            ctl,
  output logic              sdaOe
);

  slvState_t state, stateNxt;
  slvPhase_t phase, phaseNxt;
  logic      rwBit, rwNxt;
  logic      devMatch;
  logic      lastBit;

  assign devMatch = (rxByte[7:1] == {DEV_BASE[6:1], addrSel});
  assign lastBit  = (bitCnt == 3'd7);

  always_comb begin
    stateNxt = state;
    phaseNxt = phase;
    rwNxt    = rwBit;
    ctl      = '0;
    if (startDet) begin
      stateNxt   = ST_RX;
      phaseNxt   = PH_DEV;
      ctl.clrCnt = 1'b1;
    end else if (stopDet) begin
      stateNxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_RX: if (sclRise) begin
          ctl.shiftIn = 1'b1;
          if (lastBit) begin
            stateNxt = ST_ACK_WAIT;
            unique case (phase)
              PH_DEV: begin
                if (devMatch) rwNxt = rxByte[0];
                else          stateNxt = ST_IDLE;
              end
              PH_SUB:  ctl.setPtr   = 1'b1;
              PH_WR:   ctl.wrStrobe = 1'b1;
              default: stateNxt     = ST_IDLE;
            endcase
          end
        end
        ST_ACK_WAIT: if (sclFall) stateNxt = ST_ACK;
        ST_ACK: if (sclFall) begin
          if (phase == PH_DEV && rwBit) begin
            ctl.loadTx = 1'b1;
            phaseNxt   = PH_RD;
            stateNxt   = ST_TX;
          end else begin
            ctl.clrCnt = 1'b1;
            stateNxt   = ST_RX;
            if (phase == PH_DEV)      phaseNxt = PH_SUB;
            else if (phase == PH_SUB) phaseNxt = PH_WR;
          end
        end
        ST_TX: if (sclFall) begin
          if (lastBit) stateNxt    = ST_TX_ACK;
          else         ctl.shiftTx = 1'b1;
        end
        ST_TX_ACK: if (sclRise) begin
          ctl.incPtr = 1'b1;
          stateNxt   = sdaS ? ST_IDLE : ST_TX_WAIT;
        end
        ST_TX_WAIT: if (sclFall) begin
          ctl.loadTx = 1'b1;
          stateNxt   = ST_TX;
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      phase <= PH_DEV;
      rwBit <= 1'b0;
    end else begin
      state <= stateNxt;
      phase <= phaseNxt;
      rwBit <= rwNxt;
    end
  end

  assign sdaOe = (state == ST_ACK) || (state == ST_TX && !txMsb);

  assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaOe);

  assert_oe_rise_scl_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclS);

  assert_start_rematch_R9: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_RX && phase == PH_DEV));

endmodule

// File: rtl/i2c_slave_dp.sv
module i2c_slave_dp
  import i2c_slave_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              sdaS,
  input  logic [BYTE_W-1:0] regRdData,
  output logic [2:0]        bitCnt,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txMsb,
  output logic [ADDR_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regWrData,
  output logic              regWrEn,
  output logic              regRdEn
);

  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-1:0] txShift;
  logic [ADDR_W-1:0] ptr;

  assign rxByte  = {rxShift[BYTE_W-2:0], sdaS};
  assign txMsb   = txShift[BYTE_W-1];
  assign regAddr = ptr;
  assign regRdEn = ctl.loadTx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      rxShift   <= '0;
      txShift   <= '1;
      ptr       <= '0;
      regWrData <= '0;
      regWrEn   <= 1'b0;
    end else begin
      if (ctl.clrCnt || ctl.loadTx)        bitCnt <= '0;
      else if (ctl.shiftIn || ctl.shiftTx) bitCnt <= bitCnt + 3'd1;

      if (ctl.shiftIn) rxShift <= rxByte;

      if (ctl.loadTx)       txShift <= regRdData;
      else if (ctl.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b1};

      regWrEn <= ctl.wrStrobe;
      if (ctl.wrStrobe) regWrData <= rxByte;

      if (ctl.setPtr)                 ptr <= rxByte[ADDR_W-1:0];
      else if (regWrEn || ctl.incPtr) ptr <= ptr + 1'b1;
    end
  end

  assert_wr_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (regAddr == ADDR_W'($past(regAddr) + 1'b1)));

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_slave_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         BYTE_W      = 8,
  parameter int         ADDR_W      = 8,
  parameter logic [6:0] DEV_BASE    = 7'b0011000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic              addrSel,
  output logic [ADDR_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regWrData,
  output logic              regWrEn,
  output logic              regRdEn,
  input  logic [BYTE_W-1:0] regRdData
);

  logic sclS, sdaS, sclRise, sclFall, startDet, stopDet;
  logic [2:0]        bitCnt;
  logic [BYTE_W-1:0] rxByte;
  logic              txMsb;
  dpCtl_t            ctl;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2c_slave_ctrl #(.BYTE_W(BYTE_W), .DEV_BASE(DEV_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sdaS(sdaS),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet),
    .stopDet(stopDet), .addrSel(addrSel), .bitCnt(bitCnt),
    .rxByte(rxByte), .txMsb(txMsb), .ctl(ctl), .sdaOe(sdaOe)
  );

  i2c_slave_dp #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdaS(sdaS),
    .regRdData(regRdData), .bitCnt(bitCnt), .rxByte(rxByte),
    .txMsb(txMsb), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdEn(regRdEn)
  );

endmodule

// File: tb/tb_i2c_reg_slave.sv
module tb_i2c_reg_slave;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic addrSel = 1'b0;
  logic sdaOe;
  logic [7:0] regAddr, regWrData, regRdData;
  logic regWrEn, regRdEn;
  logic sdaLine;

  int checks = 0;
  int failures = 0;
  int dblPulse = 0;
  int highGlitch = 0;
  logic prevWr = 1'b0;

  logic [7:0] mem [256];
  logic [7:0] expMem [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sdaLine   = sdaM & ~sdaOe;
  assign regRdData = mem[regAddr];

  i2c_reg_slave dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .addrSel(addrSel), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regRdData(regRdData)
  );

  always @(posedge clk) begin
    if (regWrEn) mem[regAddr] <= regWrData;
    if (regWrEn && prevWr) dblPulse <= dblPulse + 1;
    prevWr <= regWrEn;
  end

  // {sel, devByte, subAddr, data, expAck}
  localparam logic [25:0] VEC [6] = '{
    {1'b0, 8'h30, 8'h05, 8'h5A, 1'b1},
    {1'b1, 8'h32, 8'h06, 8'hC3, 1'b1},
    {1'b0, 8'h32, 8'h07, 8'h11, 1'b0},
    {1'b1, 8'h30, 8'h08, 8'h22, 1'b0},
    {1'b0, 8'h20, 8'h09, 8'h33, 1'b0},
    {1'b1, 8'h32, 8'h05, 8'h77, 1'b1}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busStart;
    sdaM = 1'b1; tick(HALF/2);
    sclM = 1'b1; tick(HALF);
    sdaM = 1'b0; tick(HALF);
    sclM = 1'b0; tick(HALF/2);
  endtask

  task automatic busStop;
    sdaM = 1'b0; tick(HALF/2);
    sclM = 1'b1; tick(HALF);
    sdaM = 1'b1; tick(HALF);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; tick(HALF/2);
      sclM = 1'b1; tick(HALF);
      sclM = 1'b0; tick(HALF/2);
    end
    sdaM = 1'b1; tick(HALF/2);
    sclM = 1'b1; tick(HALF/2);
    acked = !sdaLine;
    tick(HALF/2);
    sclM = 1'b0; tick(HALF/2);
  endtask

  task automatic recvByte(input bit masterAck, output logic [7:0] b);
    logic first;
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(HALF/2);
      sclM = 1'b1; tick(2);
      first = sdaLine;
      tick(HALF/2 - 2);
      b[i] = sdaLine;
      tick(HALF/2);
      if (sdaLine != first) highGlitch++;
      sclM = 1'b0; tick(HALF/2);
    end
    sdaM = masterAck ? 1'b0 : 1'b1; tick(HALF/2);
    sclM = 1'b1; tick(HALF);
    sclM = 1'b0; tick(HALF/2);
    sdaM = 1'b1;
  endtask

  task automatic runTests;
    bit a0, a1, a2;
    logic [7:0] rb;

    // R1: reset state
    tick(3);
    check(sdaOe == 1'b0, "R1 sdaOe", sdaOe, 0);
    check(regWrEn == 1'b0, "R1 regWrEn", regWrEn, 0);
    check(regAddr == 8'h00, "R1 regAddr", regAddr, 0);
    rstN = 1'b1;
    tick(5);

    // R2 R3 R4: vector table of single-byte writes
    foreach (VEC[k]) begin
      addrSel = VEC[k][25];
      tick(4);
      busStart;
      sendByte(VEC[k][24:17], a0);
      sendByte(VEC[k][16:9], a1);
      sendByte(VEC[k][8:1], a2);
      busStop;
      tick(4);
      if (VEC[k][0]) expMem[VEC[k][16:9]] = VEC[k][8:1];
      check(a0 == VEC[k][0], "R2 device ack", a0, VEC[k][0]);
      check(a1 == VEC[k][0], "R3 sub-address ack", a1, VEC[k][0]);
      check(a2 == VEC[k][0], "R4 data ack", a2, VEC[k][0]);
      check(mem[VEC[k][16:9]] == expMem[VEC[k][16:9]], "R4 register content",
            mem[VEC[k][16:9]], expMem[VEC[k][16:9]]);
    end

    // R5: burst with wrap from 0xFE
    addrSel = 1'b0;
    busStart;
    sendByte(8'h30, a0);
    sendByte(8'hFE, a1);
    sendByte(8'h91, a2); check(a2, "R5 burst ack 0", a2, 1);
    sendByte(8'h92, a2); check(a2, "R5 burst ack 1", a2, 1);
    sendByte(8'h93, a2); check(a2, "R5 burst ack 2", a2, 1);
    busStop;
    tick(4);
    check(mem[8'hFE] == 8'h91, "R5 reg FE", mem[8'hFE], 8'h91);
    check(mem[8'hFF] == 8'h92, "R5 reg FF", mem[8'hFF], 8'h92);
    check(mem[8'h00] == 8'h93, "R5 wrap reg 00", mem[8'h00], 8'h93);
    check(regAddr == 8'h01, "R5 pointer after wrap", regAddr, 8'h01);

    // preload 0x10..0x12
    busStart;
    sendByte(8'h30, a0);
    sendByte(8'h10, a1);
    sendByte(8'hA5, a2);
    sendByte(8'h3C, a2);
    sendByte(8'h81, a2);
    busStop;
    tick(4);

    // R6 R7 R9: set pointer, repeated START, read three bytes
    busStart;
    sendByte(8'h30, a0);
    sendByte(8'h10, a1);
    busStart;
    sendByte(8'h31, a0);
    check(a0, "R9 repeated START read ack", a0, 1);
    recvByte(1'b1, rb); check(rb == 8'hA5, "R6 read byte 0", rb, 8'hA5);
    recvByte(1'b1, rb); check(rb == 8'h3C, "R7 read byte 1", rb, 8'h3C);
    recvByte(1'b0, rb); check(rb == 8'h81, "R7 read byte 2", rb, 8'h81);
    tick(4);
    check(sdaOe == 1'b0, "R7 release after NACK", sdaOe, 0);
    check(regAddr == 8'h13, "R7 pointer after read", regAddr, 8'h13);
    check(highGlitch == 0, "R6 SDA stable while SCL high", highGlitch, 0);
    busStop;
    tick(4);

    // R8: bytes after STOP are ignored
    busStart;
    sendByte(8'h30, a0);
    sendByte(8'h40, a1);
    busStop;
    tick(4);
    check(sdaOe == 1'b0, "R8 released after STOP", sdaOe, 0);
    sclM = 1'b0; tick(HALF);
    sendByte(8'h30, a0);
    check(!a0, "R8 no ack without START", a0, 0);
    sendByte(8'hEE, a1);
    check(!a1, "R8 no ack for data without START", a1, 0);
    sclM = 1'b1; tick(HALF);
    busStop;
    check(mem[8'h40] == 8'h00, "R8 no write after STOP", mem[8'h40], 0);

    // R9: repeated START with a foreign code; later bytes stay unanswered
    busStart;
    sendByte(8'h30, a0);
    sendByte(8'h50, a1);
    busStart;
    sendByte(8'h34, a0);
    check(!a0, "R9 foreign code after repeated START", a0, 0);
    sendByte(8'h66, a1);
    check(!a1, "R2 silent until next START", a1, 0);
    busStop;
    tick(4);
    check(mem[8'h50] == 8'h00, "R9 no write", mem[8'h50], 0);

    // R10
    check(dblPulse == 0, "R10 single-cycle write strobe", dblPulse, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'h00;
      expMem[i] = 8'h00;
    end
    fork
      runTests;
      begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule